// File: doc/BRIEF.md
# Forward-Edge Landing Pad Checker

This block watches a stream of retired instructions and enforces forward-edge control-flow integrity. Each retired instruction comes with a valid strobe, its program counter, its 32-bit encoding, the decoded index of its first source register and the current contents of register x7. While the CFI enable input is high, an indirect jump raises a single "pad expected" bit. The next retired instruction must then be a landing-pad instruction at a word-aligned address that carries either a zero label or a label equal to the upper twenty bits of x7.

If that rule is broken, the block emits a one-cycle exception pulse with a software-check cause code and a landing-pad-fault trap value. The pipeline that owns the trap path consumes this pulse. Returns through the link registers, and jumps guarded in software through x7, do not raise the bit. Turning off the enable quiets the block and clears the bit.

Top module: `lp_guard`

## Requirements
- R1: A retired JALR (opcode 7'b1100111, funct3 3'b000) with `cfi_en` high and `ret_rs1` not 1, 5 or 7 sets the pad-expected bit.
- R2: A JALR whose `ret_rs1` is 1, 5 or 7 leaves the pad-expected bit at 0.
- R3: While the bit is 0, any retired instruction, landing pads included, raises no exception. A landing pad (opcode 7'b0010111 with rd, bits [11:7], equal to 0) is then a no-operation, whatever its address or label.
- R4: A landing pad that retires while the bit is 1 at a PC with bits [1:0] nonzero raises an exception.
- R5: A landing pad that retires while the bit is 1 and carries a nonzero label in instruction bits [31:12] raises an exception unless that label equals `ret_x7[31:12]` exactly. A zero label accepts any x7 value.
- R6: A landing pad that retires while the bit is 1 leaves the bit at 0, whether it passes or faults.
- R7: While the bit is 1, a retired instruction that is not a landing pad raises an exception. After it, the bit holds whatever R1 and R2 give for that instruction.
- R8: While `cfi_en` is low, the bit is held at 0, JALR does not set it, and no exception is raised.
- R9: An exception appears as `exc_valid` high for exactly one cycle, in the cycle after the offending instruction's `ret_valid`, with `exc_cause` = 18 and `exc_tval` = 2. Both fields are 0 whenever `exc_valid` is low.
- R10: A cycle with `ret_valid` low changes neither the bit nor the outputs' next value, and raises no exception.
- R11: A synchronous reset (`rst` high at a clock edge) clears the bit and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfi_en | input | 1 | Enables forward-edge checking |
| ret_valid | input | 1 | A retired instruction is presented this cycle |
| ret_pc | input | XLEN | Program counter of the retired instruction |
| ret_insn | input | 32 | Encoding of the retired instruction |
| ret_rs1 | input | 5 | Decoded rs1 index of the retired instruction |
| ret_x7 | input | XLEN | Current value of register x7 |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | CAUSE_W | Exception cause, 18 when pulsing |
| exc_tval | output | XLEN | Trap value, 2 when pulsing |

## Verification
The bench drives a landing pad while no pad is expected, at a misaligned address. A design that checked without the armed bit would trap here. It sends jumps through x1, x5 and x7 and then a plain instruction, which catches a design that arms on returns or on guarded jumps. It also covers a label that differs only in the low bit of x7[31:12], and a label that matches while x7's low twelve bits are nonzero, which exposes a wrong compare window. Further cases are a missing pad followed by an arming jump, which checks that the bit re-arms after a fault, a bubble between jump and pad, a reset that lands while the bit is armed, and an AUIPC with rd nonzero that must not pass as a pad.

// File: rtl/lp_guard_pkg.sv
package lp_guard_pkg;

  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam int unsigned CAUSE_SWCHECK = 18;
  localparam int unsigned TVAL_PADFAULT = 2;

  typedef struct packed {
    logic is_jalr;
    logic is_pad;
    logic arms;
  } insn_kind_t;

endpackage

// File: rtl/lp_decode.sv
module lp_decode
  import lp_guard_pkg::*;
#(
  parameter int unsigned       LABEL_W     = 20,
  parameter logic [31:0]       EXEMPT_MASK = 32'h0000_00A2
) (
  input  logic [31:0]        insn,
  input  logic [4:0]         rs1,
  output insn_kind_t         kind,
  output logic [LABEL_W-1:0] label
);

  localparam int unsigned LBL_LSB = 32 - LABEL_W;

  logic [6:0] opc;
  logic [2:0] f3;
  logic [4:0] rd;

  always_comb begin
    opc          = insn[6:0];
    f3           = insn[14:12];
    rd           = insn[11:7];
    kind.is_jalr = (opc == OPC_JALR) && (f3 == 3'b000);
    kind.is_pad  = (opc == OPC_AUIPC) && (rd == 5'd0);
    kind.arms    = kind.is_jalr && !EXEMPT_MASK[rs1];
    label        = insn[31:LBL_LSB];
  end

endmodule

// File: rtl/lp_tracker.sv
module lp_tracker (
  input  logic clk,
  input  logic rst,
  input  logic cfi_en,
  input  logic valid,
  input  logic arms,
  output logic exp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= 1'b0;
    end else if (!cfi_en) begin
      exp_q <= 1'b0;
    end else if (valid) begin
      exp_q <= arms;
    end
  end

endmodule

// File: rtl/lp_verdict.sv
module lp_verdict
  import lp_guard_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned LABEL_W = 20
) (
  input  logic               cfi_en,
  input  logic               valid,
  input  logic               exp_q,
  input  insn_kind_t         kind,
  input  logic [LABEL_W-1:0] label,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    x7,
  output logic               fault
);

  localparam int unsigned LBL_LSB = 32 - LABEL_W;

  logic checking;
  logic misaligned;
  logic label_bad;

  always_comb begin
    checking   = valid && cfi_en && exp_q;
    misaligned = |pc[1:0];
    label_bad  = (label != '0) && (label != x7[31:LBL_LSB]);
    if (!checking)
      fault = 1'b0;
    else if (kind.is_pad)
      fault = misaligned || label_bad;
    else
      fault = 1'b1;
  end

endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lp_guard_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned LABEL_W     = 20,
  parameter int unsigned CAUSE_W     = 8,
  parameter logic [31:0] EXEMPT_MASK = 32'h0000_00A2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfi_en,
  input  logic               ret_valid,
  input  logic [XLEN-1:0]    ret_pc,
  input  logic [31:0]        ret_insn,
  input  logic [4:0]         ret_rs1,
  input  logic [XLEN-1:0]    ret_x7,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval
);

  localparam logic [CAUSE_W-1:0] CAUSE_V = CAUSE_W'(CAUSE_SWCHECK);
  localparam logic [XLEN-1:0]    TVAL_V  = XLEN'(TVAL_PADFAULT);

  insn_kind_t         kind;
  logic [LABEL_W-1:0] label;
  logic               exp_q;
  logic               fault;

  lp_decode #(.LABEL_W(LABEL_W), .EXEMPT_MASK(EXEMPT_MASK)) u_dec (
    .insn  (ret_insn),
    .rs1   (ret_rs1),
    .kind  (kind),
    .label (label)
  );

  lp_tracker u_trk (
    .clk    (clk),
    .rst    (rst),
    .cfi_en (cfi_en),
    .valid  (ret_valid),
    .arms   (kind.arms),
    .exp_q  (exp_q)
  );

  lp_verdict #(.XLEN(XLEN), .LABEL_W(LABEL_W)) u_ver (
    .cfi_en (cfi_en),
    .valid  (ret_valid),
    .exp_q  (exp_q),
    .kind   (kind),
    .label  (label),
    .pc     (ret_pc),
    .x7     (ret_x7),
    .fault  (fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_cause <= '0;
      exc_tval  <= '0;
    end else begin
      exc_valid <= fault;
      exc_cause <= fault ? CAUSE_V : '0;
      exc_tval  <= fault ? TVAL_V  : '0;
    end
  end

endmodule

// File: rtl/lp_guard_chk.sv
module lp_guard_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cfi_en,
  input logic               ret_valid,
  input logic [31:0]        ret_insn,
  input logic [4:0]         ret_rs1,
  input logic               exp_q,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic [XLEN-1:0]    exc_tval
);

  logic jalr_seen, exempt, pad_seen;
  assign jalr_seen = (ret_insn[6:0] == 7'b1100111) && (ret_insn[14:12] == 3'b000);
  assign exempt    = (ret_rs1 == 5'd1) || (ret_rs1 == 5'd5) || (ret_rs1 == 5'd7);
  assign pad_seen  = (ret_insn[6:0] == 7'b0010111) && (ret_insn[11:7] == 5'd0);

  a_r1_arm: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && cfi_en && jalr_seen && !exempt) |=> exp_q);

  a_r2_exempt: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && cfi_en && jalr_seen && exempt) |=> !exp_q);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!exp_q) |=> !exc_valid);

  a_r6_pad_clears: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && cfi_en && exp_q && pad_seen) |=> !exp_q);

  a_r7_missing_pad: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && cfi_en && exp_q && !pad_seen) |=> exc_valid);

  a_r8_disabled: assert property (@(posedge clk) disable iff (rst)
    (!cfi_en) |=> (!exp_q && !exc_valid));

  a_r9_codes: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause == CAUSE_W'(18) && exc_tval == XLEN'(2)));

  a_r9_quiet_fields: assert property (@(posedge clk) disable iff (rst)
    (!exc_valid) |-> (exc_cause == '0 && exc_tval == '0));

  a_r10_bubble_holds: assert property (@(posedge clk) disable iff (rst)
    (!ret_valid && cfi_en) |=> ($stable(exp_q) && !exc_valid));

endmodule

bind lp_guard lp_guard_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfi_en    (cfi_en),
  .ret_valid (ret_valid),
  .ret_insn  (ret_insn),
  .ret_rs1   (ret_rs1),
  .exp_q     (exp_q),
  .exc_valid (exc_valid),
  .exc_cause (exc_cause),
  .exc_tval  (exc_tval)
);

// File: tb/lp_guard_test.sv
`timescale 1ns/1ps
module lp_guard_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfi_en = 1'b0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_pc = '0;
  logic [31:0] ret_insn = '0;
  logic [4:0]  ret_rs1 = '0;
  logic [31:0] ret_x7 = '0;
  logic        exc_valid;
  logic [7:0]  exc_cause;
  logic [31:0] exc_tval;

  int applied = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  lp_guard uut (
    .clk(clk), .rst(rst), .cfi_en(cfi_en), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_insn(ret_insn), .ret_rs1(ret_rs1), .ret_x7(ret_x7),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
  );

  typedef struct packed {
    logic        en;
    logic        vld;
    logic [31:0] pc;
    logic [31:0] insn;
    logic [4:0]  rs1;
    logic [31:0] x7;
    logic        exc;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] jalr(input logic [4:0] r);
    return {12'h000, r, 3'b000, 5'd0, 7'b1100111};
  endfunction
  function automatic logic [31:0] pad(input logic [19:0] l);
    return {l, 5'd0, 7'b0010111};
  endfunction
  localparam logic [31:0] NOP  = 32'h0000_0013;
  localparam logic [31:0] AUI3 = {20'h00005, 5'd3, 7'b0010111};

  function automatic vec_t mk(input logic e, input logic v, input logic [31:0] p,
                              input logic [31:0] i, input logic [4:0] r,
                              input logic [31:0] x, input logic ex, input logic [3:0] q);
    return '{en:e, vld:v, pc:p, insn:i, rs1:r, x7:x, exc:ex, req:q};
  endfunction

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    mk(1,1,32'h100, NOP,            0, 0,            0, 3),  // R3 plain
    mk(1,1,32'h102, pad(20'h0),     0, 0,            0, 3),  // R3 pad idle, misaligned
    mk(1,1,32'h104, jalr(6),        6, 0,            0, 1),  // R1 arm
    mk(1,1,32'h200, pad(20'h0),     0, 32'hFFFFF000, 0, 5),  // R5 zero label
    mk(1,1,32'h202, pad(20'h0),     0, 0,            0, 6),  // R6 cleared
    mk(1,1,32'h204, jalr(10),      10, 0,            0, 1),  // R1
    mk(1,1,32'h202, pad(20'h0),     0, 0,            1, 4),  // R4 misaligned
    mk(1,1,32'h208, NOP,            0, 0,            0, 6),  // R6 cleared after fault
    mk(1,1,32'h20C, jalr(1),        1, 0,            0, 2),  // R2 x1
    mk(1,1,32'h210, NOP,            0, 0,            0, 2),
    mk(1,1,32'h214, jalr(5),        5, 0,            0, 2),  // R2 x5
    mk(1,1,32'h218, NOP,            0, 0,            0, 2),
    mk(1,1,32'h21C, jalr(7),        7, 0,            0, 2),  // R2 x7
    mk(1,1,32'h220, NOP,            0, 0,            0, 2),
    mk(1,1,32'h224, jalr(11),      11, 0,            0, 1),
    mk(1,1,32'h228, NOP,            0, 0,            1, 7),  // R7 missing pad
    mk(1,1,32'h22C, jalr(12),      12, 0,            0, 1),
    mk(1,1,32'h300, pad(20'h12345), 0, 32'h12345ABC, 0, 5),  // R5 match, low bits ignored
    mk(1,1,32'h304, jalr(12),      12, 0,            0, 1),
    mk(1,1,32'h308, pad(20'h12345), 0, 32'h12344000, 1, 5),  // R5 mismatch low bit
    mk(1,1,32'h30C, jalr(12),      12, 0,            0, 1),
    mk(1,0,32'h310, NOP,            0, 0,            0, 10), // R10 bubble
    mk(1,1,32'h314, pad(20'h12345), 0, 32'h12345000, 0, 10), // R10 pad still expected, passes
    mk(1,1,32'h318, NOP,            0, 0,            0, 6),
    mk(0,1,32'h31C, jalr(12),      12, 0,            0, 8),  // R8 no arm when off
    mk(1,1,32'h320, NOP,            0, 0,            0, 8),
    mk(1,1,32'h324, jalr(13),      13, 0,            0, 1),
    mk(0,1,32'h328, NOP,            0, 0,            0, 8),  // R8 off clears bit
    mk(1,1,32'h32C, NOP,            0, 0,            0, 8),
    mk(1,1,32'h330, jalr(13),      13, 0,            0, 1),
    mk(1,1,32'h334, jalr(14),      14, 0,            1, 7),  // R7 fault, re-arms
    mk(1,1,32'h406, pad(20'h0),     0, 0,            1, 7),  // R7 re-armed: misaligned faults
    mk(1,1,32'h408, jalr(9),        9, 0,            0, 1),
    mk(1,1,32'h40C, AUI3,           0, 0,            1, 3)   // R3 rd!=0 is not a pad
  };

  task automatic check(input logic ev, input int req, input string tag);
    logic [7:0]  ec;
    logic [31:0] et;
    ec = ev ? 8'd18 : 8'd0;
    et = ev ? 32'd2 : 32'd0;
    applied++;
    if (exc_valid !== ev || exc_cause !== ec || exc_tval !== et) begin
      miscmp++;
      $display("FAIL R%0d %s: got v=%0b c=%0d t=%0d exp v=%0b c=%0d t=%0d",
               req, tag, exc_valid, exc_cause, exc_tval, ev, ec, et);
    end
  endtask

  task automatic drive(input vec_t v);
    cfi_en = v.en; ret_valid = v.vld; ret_pc = v.pc;
    ret_insn = v.insn; ret_rs1 = v.rs1; ret_x7 = v.x7;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 11, "R11 reset state");
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(VEC[i].exc, int'(VEC[i].req), $sformatf("vector %0d", i));
    end
    // R11: reset while armed clears the bit
    drive(mk(1,1,32'h500, jalr(20), 20, 0, 0, 11));
    @(negedge clk);
    check(1'b0, 11, "R11 arm before reset");
    ret_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, 11, "R11 outputs in reset");
    rst = 1'b0;
    drive(mk(1,1,32'h504, NOP, 0, 0, 0, 11));
    @(negedge clk);
    check(1'b0, 11, "R11 bit cleared by reset");
    // R9: single-cycle pulse
    drive(mk(1,1,32'h508, jalr(20), 20, 0, 0, 9));
    @(negedge clk);
    drive(mk(1,1,32'h50A, pad(20'h0), 0, 0, 0, 9));
    @(negedge clk);
    check(1'b1, 9, "R9 pulse");
    ret_valid = 1'b0;
    @(negedge clk);
    check(1'b0, 9, "R9 pulse ends");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule